// File: doc/BRIEF.md
# Table-Driven Programmable State Machine

This block is a finite state machine whose transition function and output function are held in two rewritable on-chip tables, not in synthesized logic. Each clock, the current state and the input vector together select one entry of the transition table. That entry is captured into the state register, so the register is also the table's read-data register. A second table supplies the output word. In the default mode it is indexed by the same state-plus-input word, which gives Mealy outputs. A parameter switches it to a state-only table, which gives Moore outputs.

A host changes the machine's behaviour at run time by rewriting table entries through a small write port, without re-synthesis. Writes are accepted only while the hold input freezes the machine, so a transition never reads a half-written table. The address is the input bits appended below the state bits, and every extra input bit doubles the table depth. State width and input width are therefore kept small by parameter.

Top module: `pfsm_top`

## Requirements
- R1: While reset is sampled high at a rising edge, the state becomes INIT_STATE after that edge. In Mealy mode the output becomes all zeros. Table contents are not cleared.
- R2: At each rising edge with reset low and hold low, the state becomes the transition-table entry at address {state, inVec}, with the state in the upper STATE_W bits and the input in the lower IN_W bits.
- R3: In Mealy mode (MEALY=1), the output after each advancing edge is the output-table entry at the same {state, inVec} address used by that edge's transition.
- R4: In Moore mode (MEALY=0), the output is at all times the output-table entry of the current state. That entry is written through any address whose upper STATE_W bits equal the state.
- R5: While hold is high and reset is low, the state and the Mealy output register keep their values, whatever the inputs are.
- R6: A write with wrEn high while hold is high updates the entry at wrAddr. wrSel=0 selects the transition table, which takes the low STATE_W bits of wrData. wrSel=1 selects the output table, which takes the low OUT_W bits of wrData. The new entry governs all later transitions.
- R7: A write with wrEn high while hold is low leaves both tables unchanged.
- R8: Reset has priority over hold. With both high, the state still goes to INIT_STATE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset to the initial state |
| hold | input | 1 | Freezes the machine and enables table writes |
| inVec | input | IN_W | External inputs, lower address field |
| wrAddr | input | STATE_W+IN_W | Table entry address for writes |
| wrData | input | max(STATE_W,OUT_W) | Write data, low bits used per table |
| wrSel | input | 1 | 0 selects the transition table, 1 the output table |
| wrEn | input | 1 | Write strobe, effective only under hold |
| stateOut | output | STATE_W | Current state register |
| outVec | output | OUT_W | Output word from the output table |

## Verification
The hardest situation to reach is a write that arrives while the machine runs and aims at an entry the machine will later read. Its effect shows up only cycles afterwards, when the inputs steer the machine to that entry. The stimulus sweeps ignored writes of inverted data across every address of both tables during a random run. It then keeps walking random inputs, so that all entries are revisited against the unchanged model. A second pass rewrites whole tables under hold and confirms that the machine follows the new contents.

// File: rtl/pfsm_pkg.sv
package pfsm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadInit;  // force state to initial code
    logic advance;   // capture table read into registers
    logic wrNext;    // write transition table
    logic wrOut;     // write output table
  } fsmStrobe_t;
endpackage

// File: rtl/pfsm_ctrl.sv
module pfsm_ctrl
  import pfsm_pkg::*;
(
  input  logic       rst,
  input  logic       hold,
  input  logic       wrEn,
  input  logic       wrSel,
  output fsmStrobe_t strb
);
  always_comb begin
    strb.loadInit = rst;
    strb.advance  = !rst && !hold;
    // table updates only while the machine is frozen
    strb.wrNext   = hold && wrEn && !wrSel;
    strb.wrOut    = hold && wrEn && wrSel;
  end
endmodule

// File: rtl/pfsm_datapath.sv
module pfsm_datapath
  import pfsm_pkg::*;
#(
  parameter int unsigned STATE_W    = 3,
  parameter int unsigned IN_W       = 2,
  parameter int unsigned OUT_W      = 4,
  parameter int unsigned INIT_STATE = 0,
  parameter bit          MEALY      = 1'b1,
  localparam int unsigned ADDR_W    = STATE_W + IN_W,
  localparam int unsigned DATA_W    = (STATE_W > OUT_W) ? STATE_W : OUT_W
)(
  input  logic               clk,
  input  fsmStrobe_t         strb,
  input  logic [IN_W-1:0]    inVec,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [STATE_W-1:0] stateQ,
  output logic [OUT_W-1:0]   outVec
);
  localparam int unsigned TBL_DEPTH   = 2 ** ADDR_W;
  localparam int unsigned STATE_DEPTH = 2 ** STATE_W;
  localparam logic [STATE_W-1:0] INIT_CODE = STATE_W'(INIT_STATE);

  logic [STATE_W-1:0] nextMem [TBL_DEPTH];
  logic [ADDR_W-1:0]  readAddr;

  assign readAddr = {stateQ, inVec};

  always_ff @(posedge clk) begin
    if (strb.wrNext) nextMem[wrAddr] <= wrData[STATE_W-1:0];
  end

  // state register doubles as the transition table's read-data register
  always_ff @(posedge clk) begin
    if (strb.loadInit)     stateQ <= INIT_CODE;
    else if (strb.advance) stateQ <= nextMem[readAddr];
  end

  generate
    if (MEALY) begin : g_mealy
      logic [OUT_W-1:0] outMem [TBL_DEPTH];
      logic [OUT_W-1:0] outQ;
      always_ff @(posedge clk) begin
        if (strb.wrOut) outMem[wrAddr] <= wrData[OUT_W-1:0];
      end
      // output register is the output table's read-data register
      always_ff @(posedge clk) begin
        if (strb.loadInit)     outQ <= '0;
        else if (strb.advance) outQ <= outMem[readAddr];
      end
      assign outVec = outQ;
    end else begin : g_moore
      logic [OUT_W-1:0] outMem [STATE_DEPTH];
      always_ff @(posedge clk) begin
        if (strb.wrOut) outMem[wrAddr[ADDR_W-1:IN_W]] <= wrData[OUT_W-1:0];
      end
      // state register serves as this table's registered address
      assign outVec = outMem[stateQ];
    end
  endgenerate
endmodule

// File: rtl/pfsm_top.sv
module pfsm_top
  import pfsm_pkg::*;
#(
  parameter int unsigned STATE_W    = 3,
  parameter int unsigned IN_W       = 2,
  parameter int unsigned OUT_W      = 4,
  parameter int unsigned INIT_STATE = 0,
  parameter bit          MEALY      = 1'b1,
  localparam int unsigned ADDR_W    = STATE_W + IN_W,
  localparam int unsigned DATA_W    = (STATE_W > OUT_W) ? STATE_W : OUT_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic [IN_W-1:0]    inVec,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrSel,
  input  logic               wrEn,
  output logic [STATE_W-1:0] stateOut,
  output logic [OUT_W-1:0]   outVec
);
  fsmStrobe_t strb;

  pfsm_ctrl ctrl_i (
    .rst   (rst),
    .hold  (hold),
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .strb  (strb)
  );

  pfsm_datapath #(
    .STATE_W    (STATE_W),
    .IN_W       (IN_W),
    .OUT_W      (OUT_W),
    .INIT_STATE (INIT_STATE),
    .MEALY      (MEALY)
  ) dp_i (
    .clk    (clk),
    .strb   (strb),
    .inVec  (inVec),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .stateQ (stateOut),
    .outVec (outVec)
  );
endmodule

// File: rtl/pfsm_chk.sv
module pfsm_chk #(
  parameter int unsigned STATE_W    = 3,
  parameter int unsigned OUT_W      = 4,
  parameter int unsigned INIT_STATE = 0,
  parameter bit          MEALY      = 1'b1
)(
  input logic               clk,
  input logic               rst,
  input logic               hold,
  input logic [STATE_W-1:0] stateOut,
  input logic [OUT_W-1:0]   outVec
);
  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  // R1 and R8: after a reset edge the state is the initial code
  always @(negedge clk) begin
    if (rstQ) begin
      a_reset_state_r1: assert (stateOut == STATE_W'(INIT_STATE))
        else $error("state not initial after reset");
    end
  end

  // R5: hold freezes the state
  p_hold_state_r5: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(stateOut));

  generate
    if (MEALY) begin : g_mealy_chk
      // R1: Mealy output cleared by reset
      always @(negedge clk) begin
        if (rstQ) begin
          a_reset_out_r1: assert (outVec == '0)
            else $error("output not cleared after reset");
        end
      end
      // R5: hold freezes the Mealy output register
      p_hold_out_r5: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(outVec));
    end
  endgenerate
endmodule

bind pfsm_top pfsm_chk #(
  .STATE_W    (STATE_W),
  .OUT_W      (OUT_W),
  .INIT_STATE (INIT_STATE),
  .MEALY      (MEALY)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .hold     (hold),
  .stateOut (stateOut),
  .outVec   (outVec)
);

// File: tb/pfsm_top_tb_top.sv
module pfsm_top_tb_top;
  localparam int SW = 3;
  localparam int IW = 2;
  localparam int OW = 4;
  localparam int AW = SW + IW;
  localparam int DW = 4;
  localparam int MOORE_INIT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hold = 1'b1;
  logic [IW-1:0] inVec = '0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic wrSel = 1'b0;
  logic wrEnA = 1'b0;
  logic wrEnB = 1'b0;
  logic [SW-1:0] stateA, stateB;
  logic [OW-1:0] outA, outB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [SW-1:0] nsT  [32];
  logic [OW-1:0] outT [32];
  logic [OW-1:0] mooT [8];
  logic [SW-1:0] expStA, expStB;
  logic [OW-1:0] expOutA;

  always #10 clk = ~clk;

  pfsm_top dut_i (
    .clk(clk), .rst(rst), .hold(hold), .inVec(inVec),
    .wrAddr(wrAddr), .wrData(wrData), .wrSel(wrSel), .wrEn(wrEnA),
    .stateOut(stateA), .outVec(outA)
  );

  pfsm_top #(.INIT_STATE(MOORE_INIT), .MEALY(1'b0)) dutMoore_i (
    .clk(clk), .rst(rst), .hold(hold), .inVec(inVec),
    .wrAddr(wrAddr), .wrData(wrData), .wrSel(wrSel), .wrEn(wrEnB),
    .stateOut(stateB), .outVec(outB)
  );

  function automatic logic [SW-1:0] nextOf(logic [SW-1:0] s, logic [IW-1:0] i);
    return nsT[{s, i}];
  endfunction

  function automatic logic [OW-1:0] mealyOf(logic [SW-1:0] s, logic [IW-1:0] i);
    return outT[{s, i}];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeEntry(logic sel, logic [AW-1:0] a, logic [DW-1:0] d,
                            logic enA, logic enB);
    wrSel = sel; wrAddr = a; wrData = d; wrEnA = enA; wrEnB = enB;
    @(posedge clk); @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  // R6: load fresh tables through the write port while held
  task automatic loadTables();
    for (int a = 0; a < 32; a++) begin
      nsT[a] = SW'($urandom);
      writeEntry(1'b0, AW'(a), DW'(nsT[a]), 1'b1, 1'b1);
      outT[a] = OW'($urandom);
      writeEntry(1'b1, AW'(a), DW'(outT[a]), 1'b1, 1'b0);
    end
    for (int s = 0; s < 8; s++) begin
      mooT[s] = OW'($urandom);
      writeEntry(1'b1, {SW'(s), IW'($urandom)}, DW'(mooT[s]), 1'b0, 1'b1);
    end
  endtask

  // one cycle: drive at negedge, sample at next negedge
  task automatic step(logic [IW-1:0] i);
    inVec = i;
    if (!hold && !rst) begin
      expOutA = mealyOf(expStA, i);
      expStA  = nextOf(expStA, i);
      expStB  = nextOf(expStB, i);
    end
    @(posedge clk); @(negedge clk);
    if (hold) begin
      chk("R5 state held", 8'(stateA), 8'(expStA));
      chk("R5 output held", 8'(outA), 8'(expOutA));
    end else begin
      chk("R2 next state", 8'(stateA), 8'(expStA));
      chk("R3 mealy output", 8'(outA), 8'(expOutA));
    end
    chk("R2 moore next state", 8'(stateB), 8'(expStB));
    chk("R4 moore output", 8'(outB), 8'(mooT[expStB]));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'h1f3c5a77));
    @(negedge clk);
    loadTables();
    rst = 1'b0;
    expStA = '0; expOutA = '0; expStB = SW'(MOORE_INIT);
    @(posedge clk); @(negedge clk);
    chk("R1 reset state", 8'(stateA), 8'h0);
    chk("R1 reset output", 8'(outA), 8'h0);
    chk("R1 moore reset state", 8'(stateB), 8'(MOORE_INIT));
    chk("R4 moore output at init", 8'(outB), 8'(mooT[MOORE_INIT]));

    // R5: held with changing inputs
    for (int k = 0; k < 4; k++) step(IW'(k));

    // R2 R3 R4: free run, directed input sweep then random
    hold = 1'b0;
    for (int k = 0; k < 8; k++) step(IW'(k));
    for (int k = 0; k < 200; k++) step(IW'($urandom));

    // R5: freeze mid-run
    hold = 1'b1;
    for (int k = 0; k < 6; k++) step(IW'($urandom));
    hold = 1'b0;

    // R7: writes of inverted data while running are ignored
    for (int k = 0; k < 64; k++) begin
      wrSel  = k[0];
      wrAddr = AW'(k >> 1);
      wrData = ~DW'(k[0] ? outT[k >> 1] : nsT[k >> 1]);
      wrEnA  = 1'b1; wrEnB = 1'b1;
      step(IW'($urandom));
    end
    wrEnA = 1'b0; wrEnB = 1'b0;
    for (int k = 0; k < 150; k++) step(IW'($urandom));

    // R6: rewrite both tables under hold, behaviour follows the new content
    hold = 1'b1;
    loadTables();
    chk("R6 moore output after rewrite", 8'(outB), 8'(mooT[expStB]));
    hold = 1'b0;
    for (int k = 0; k < 200; k++) step(IW'($urandom));

    // R8: reset wins over hold
    hold = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R8 reset over hold state", 8'(stateA), 8'h0);
    chk("R8 reset over hold output", 8'(outA), 8'h0);
    chk("R8 moore reset over hold", 8'(stateB), 8'(MOORE_INIT));
    rst = 1'b0; hold = 1'b0;
    expStA = '0; expOutA = '0; expStB = SW'(MOORE_INIT);
    for (int k = 0; k < 50; k++) step(IW'($urandom));

    summary();
  end
endmodule